// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator as two 32-bit words (high and low) and adds signed products to it. A request on `start_i` selects one of two product forms. The long form multiplies the full 32-bit operands. The word form multiplies only the sign-extended low halves of the operands. The product passes through a two-stage register pipeline and is then added to the accumulator.

With `sat_i` low, the whole 64-bit sum is written back. With `sat_i` high, the write-back depends on the form. The long form keeps the low word and forces the high word into a 16-bit-limited shape: ones on top when the sum is negative, masked to 15 bits otherwise. The word form clamps any sum outside the signed 32-bit range to a sentinel pair: high word 1 and a low word at the limit that was crossed.

Software-style direct access is limited to per-word clear and load ports. A direct access beats a write-back in the same cycle.

Top module: `smac_top`

## Requirements
- R1: While `rst_ni` is low, both accumulator words read 0 and `done_o` is low.
- R2: A request sampled with `start_i` high on clock edge k writes back on edge k+2. `done_o` is high for exactly the one cycle after that edge, when the new accumulator value is visible.
- R3: With `op_word_i`=0 and `sat_i`=0, the accumulator becomes ({hi,lo} + signed(a_i) * signed(b_i)) modulo 2^64. The high word takes bits 63:32 and the low word takes bits 31:0.
- R4: With `op_word_i`=1, the product is signed(a_i[15:0]) * signed(b_i[15:0]). Bits 31:16 of both operands have no effect.
- R5: With `op_word_i`=0 and `sat_i`=1, the low word takes sum bits 31:0. The high word takes sum bits 63:32 OR 0xFFFF0000 when the 64-bit sum is negative, and sum bits 63:32 AND 0x00007FFF otherwise.
- R6: With `op_word_i`=1 and `sat_i`=1, a 64-bit sum below -0x80000000 writes high word 0x00000001 and low word 0x80000000. A sum of exactly -0x80000000 is written unchanged.
- R7: With `op_word_i`=1 and `sat_i`=1, a sum above 0x7FFFFFFF writes high word 0x00000001 and low word 0x7FFFFFFF. A sum inside [-0x80000000, 0x7FFFFFFF] is written back unchanged as 64 bits.
- R8: Per word, on a clock edge, a clear (`*_clr_i`) sets the word to 0. Otherwise a load (`*_ld_i`) sets it to its data port. Otherwise a write-back updates it. Both clear and load take priority over a write-back that lands on the same edge, and each affects only its own word.
- R9: Requests on consecutive cycles accumulate in order: each write-back adds to the value left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_word_i | input | 1 | 0: long 32x32 form, 1: word 16x16 form |
| start_i | input | 1 | Request strobe |
| sat_i | input | 1 | Saturation mode for this request |
| hi_clr_i | input | 1 | Clear high word |
| hi_ld_i | input | 1 | Load high word from hi_data_i |
| hi_data_i | input | 32 | High word load value |
| lo_clr_i | input | 1 | Clear low word |
| lo_ld_i | input | 1 | Load low word from lo_data_i |
| lo_data_i | input | 32 | Low word load value |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | One-cycle write-back strobe |

## Verification
The bench builds the block with its default 32-bit data width, so operands, sums and saturation limits all fit the bench's 64-bit integer model exactly. At this width the directed cases can place the accumulator one step on either side of ±2^31. They can also put the operand sign bit at bit 15 for the word form, and can make a direct load land on the very edge of a write-back. Random requests with random preloads then mix both forms and both saturation modes around those limits.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/smac_mul.sv
// Two-stage signed multiplier: operand select/extend, then product register.
module smac_mul
  import smac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  mac_op_e               op_i,
  input  logic                  sat_i,
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  output logic                  vld_o,
  output mac_op_e               op_o,
  output logic                  sat_o,
  output logic [2*DATA_W-1:0]   prod_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;

  logic [DATA_W-1:0] a_sel, b_sel;
  logic [DATA_W-1:0] s1_a, s1_b;
  logic              s1_vld, s1_sat;
  mac_op_e           s1_op;
  logic [ACC_W-1:0]  a_ext, b_ext, prod_d;

  always_comb begin
    if (op_i == MAC_WORD) begin
      a_sel = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
      b_sel = {{HALF_W{b_i[HALF_W-1]}}, b_i[HALF_W-1:0]};
    end else begin
      a_sel = a_i;
      b_sel = b_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_op  <= MAC_LONG;
      s1_sat <= 1'b0;
      s1_a   <= '0;
      s1_b   <= '0;
    end else begin
      s1_vld <= vld_i;
      if (vld_i) begin
        s1_op  <= op_i;
        s1_sat <= sat_i;
        s1_a   <= a_sel;
        s1_b   <= b_sel;
      end
    end
  end

  // low ACC_W bits of the extended product equal the signed product
  assign a_ext  = {{DATA_W{s1_a[DATA_W-1]}}, s1_a};
  assign b_ext  = {{DATA_W{s1_b[DATA_W-1]}}, s1_b};
  assign prod_d = a_ext * b_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      op_o   <= MAC_LONG;
      sat_o  <= 1'b0;
      prod_o <= '0;
    end else begin
      vld_o <= s1_vld;
      if (s1_vld) begin
        op_o   <= s1_op;
        sat_o  <= s1_sat;
        prod_o <= prod_d;
      end
    end
  end
endmodule

// File: rtl/smac_sat.sv
// Sum and write-back shaping for both forms.
module smac_sat
  import smac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2*DATA_W-1:0] acc_i,
  input  logic [2*DATA_W-1:0] prod_i,
  input  mac_op_e             op_i,
  input  logic                sat_i,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;
  localparam logic [DATA_W-1:0] HI_NEG_OR  = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
  localparam logic [DATA_W-1:0] HI_POS_AND = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  SUM_MIN    = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]  SUM_MAX    = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SENT_HI    = DATA_W'(1);
  localparam logic [DATA_W-1:0] LO_MIN     = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] LO_MAX     = {1'b0, {(DATA_W-1){1'b1}}};

  logic [ACC_W-1:0]  sum;
  logic [DATA_W-1:0] sum_hi, sum_lo;
  logic              below, above;

  assign sum    = acc_i + prod_i;
  assign sum_hi = sum[ACC_W-1:DATA_W];
  assign sum_lo = sum[DATA_W-1:0];
  assign below  = $signed(sum) < $signed(SUM_MIN);
  assign above  = $signed(sum) > $signed(SUM_MAX);

  always_comb begin
    hi_o = sum_hi;
    lo_o = sum_lo;
    if (sat_i) begin
      if (op_i == MAC_LONG) begin
        hi_o = sum[ACC_W-1] ? (sum_hi | HI_NEG_OR) : (sum_hi & HI_POS_AND);
      end else if (below) begin
        hi_o = SENT_HI;
        lo_o = LO_MIN;
      end else if (above) begin
        hi_o = SENT_HI;
        lo_o = LO_MAX;
      end
    end
  end
endmodule

// File: rtl/smac_acc.sv
// Accumulator words with per-word clear > load > write-back priority.
module smac_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_i,
  input  logic [DATA_W-1:0] wb_hi_i,
  input  logic [DATA_W-1:0] wb_lo_i,
  input  logic              hi_clr_i,
  input  logic              hi_ld_i,
  input  logic [DATA_W-1:0] hi_data_i,
  input  logic              lo_clr_i,
  input  logic              lo_ld_i,
  input  logic [DATA_W-1:0] lo_data_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              done_o
);
  logic [1:0]             clr_v, ld_v;
  logic [1:0][DATA_W-1:0] data_v, wbv_v, q_v;

  assign clr_v  = {hi_clr_i, lo_clr_i};
  assign ld_v   = {hi_ld_i, lo_ld_i};
  assign data_v = {hi_data_i, lo_data_i};
  assign wbv_v  = {wb_hi_i, wb_lo_i};

  for (genvar w = 0; w < 2; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_v[w] <= '0;
      else if (clr_v[w])  q_v[w] <= '0;
      else if (ld_v[w])   q_v[w] <= data_v[w];
      else if (wb_i)      q_v[w] <= wbv_v[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= wb_i;
  end

  assign hi_o = q_v[1];
  assign lo_o = q_v[0];

  p_hi_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_clr_i |=> hi_o == '0);
  p_lo_ld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_ld_i && !lo_clr_i) |=> lo_o == $past(lo_data_i));
  p_hi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_clr_i && !hi_ld_i && !wb_i) |=> $stable(hi_o));
endmodule

// File: rtl/smac_top.sv
module smac_top
  import smac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              op_word_i,
  input  logic              start_i,
  input  logic              sat_i,
  input  logic              hi_clr_i,
  input  logic              hi_ld_i,
  input  logic [DATA_W-1:0] hi_data_i,
  input  logic              lo_clr_i,
  input  logic              lo_ld_i,
  input  logic [DATA_W-1:0] lo_data_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [ACC_W-1:0] SUM_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] SUM_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};

  mac_op_e           req_op, wb_op;
  logic              wb_vld, wb_sat;
  logic [ACC_W-1:0]  wb_prod;
  logic [DATA_W-1:0] wb_hi, wb_lo;

  assign req_op = op_word_i ? MAC_WORD : MAC_LONG;

  smac_mul #(.DATA_W(DATA_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (start_i),
    .op_i   (req_op),
    .sat_i  (sat_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .vld_o  (wb_vld),
    .op_o   (wb_op),
    .sat_o  (wb_sat),
    .prod_o (wb_prod)
  );

  smac_sat #(.DATA_W(DATA_W)) u_sat (
    .acc_i  ({acc_hi_o, acc_lo_o}),
    .prod_i (wb_prod),
    .op_i   (wb_op),
    .sat_i  (wb_sat),
    .hi_o   (wb_hi),
    .lo_o   (wb_lo)
  );

  smac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wb_i      (wb_vld),
    .wb_hi_i   (wb_hi),
    .wb_lo_i   (wb_lo),
    .hi_clr_i  (hi_clr_i),
    .hi_ld_i   (hi_ld_i),
    .hi_data_i (hi_data_i),
    .lo_clr_i  (lo_clr_i),
    .lo_ld_i   (lo_ld_i),
    .lo_data_i (lo_data_i),
    .hi_o      (acc_hi_o),
    .lo_o      (acc_lo_o),
    .done_o    (done_o)
  );

  logic no_direct;
  assign no_direct = !hi_clr_i && !hi_ld_i && !lo_clr_i && !lo_ld_i;

  p_done_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 3));
  p_long_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld && wb_op == MAC_LONG && wb_sat && !hi_clr_i && !hi_ld_i) |=>
      (acc_hi_o[DATA_W-1:HALF_W] == '1 || acc_hi_o[DATA_W-1:HALF_W-1] == '0));
  p_word_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld && wb_op == MAC_WORD && wb_sat && no_direct) |=>
      (($signed({acc_hi_o, acc_lo_o}) >= $signed(SUM_MIN) &&
        $signed({acc_hi_o, acc_lo_o}) <= $signed(SUM_MAX)) ||
       (acc_hi_o == DATA_W'(1) &&
        (acc_lo_o == SUM_MIN[DATA_W-1:0] || acc_lo_o == SUM_MAX[DATA_W-1:0]))));
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(start_i, 2)) |=> !done_o);
endmodule

// File: tb/smac_top_tb_top.sv
module smac_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0, hi_data = '0, lo_data = '0;
  logic        op_word = 1'b0, start = 1'b0, sat = 1'b0;
  logic        hi_clr = 1'b0, hi_ld = 1'b0, lo_clr = 1'b0, lo_ld = 1'b0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] m_hi = '0, m_lo = '0;

  always #5 clk = ~clk;

  smac_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_word_i(op_word),
    .start_i(start), .sat_i(sat), .hi_clr_i(hi_clr), .hi_ld_i(hi_ld),
    .hi_data_i(hi_data), .lo_clr_i(lo_clr), .lo_ld_i(lo_ld), .lo_data_i(lo_data),
    .acc_hi_o(acc_hi), .acc_lo_o(acc_lo), .done_o(done)
  );

  function automatic logic [63:0] ref_mac(logic [63:0] acc, logic [31:0] x,
                                          logic [31:0] y, bit word, bit sm);
    longint p, s;
    logic [31:0] h, l;
    if (word) p = longint'($signed(x[15:0])) * longint'($signed(y[15:0]));
    else      p = longint'($signed(x)) * longint'($signed(y));
    s = longint'(acc) + p;
    h = s[63:32];
    l = s[31:0];
    if (sm && !word) begin
      if (s < 0) h = h | 32'hFFFF0000;
      else       h = h & 32'h00007FFF;
    end else if (sm && word) begin
      if (s < -64'sh80000000)     begin h = 32'd1; l = 32'h80000000; end
      else if (s > 64'sh7FFFFFFF) begin h = 32'd1; l = 32'h7FFFFFFF; end
    end
    return {h, l};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [31:0] h, logic [31:0] l);
    @(negedge clk);
    hi_ld = 1'b1; lo_ld = 1'b1; hi_data = h; lo_data = l;
    @(negedge clk);
    hi_ld = 1'b0; lo_ld = 1'b0;
    m_hi = h; m_lo = l;
  endtask

  // start at one negedge; result visible three negedges later
  task automatic mac(logic [31:0] x, logic [31:0] y, bit word, bit sm, string req);
    logic [63:0] e;
    @(negedge clk);
    a = x; b = y; op_word = word; sat = sm; start = 1'b1;
    e = ref_mac({m_hi, m_lo}, x, y, word, sm);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk({req, " pre-done"}, {63'd0, done}, 64'd0);
    @(negedge clk);
    chk({req, " done"}, {63'd0, done}, 64'd1);
    chk(req, {acc_hi, acc_lo}, e);
    {m_hi, m_lo} = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset", {acc_hi, acc_lo}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    rst_n = 1'b1;

    mac(32'd7, 32'hFFFFFFFD, 1'b0, 1'b0, "R3 small neg");
    @(negedge clk);
    chk("R2 pulse ends", {63'd0, done}, 64'd0);
    load(32'h00000001, 32'hFFFFFFFF);
    mac(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, "R3 carry");
    load(32'h7FFFFFFF, 32'hFFFFFFFF);
    mac(32'd1, 32'd1, 1'b0, 1'b0, "R3 wrap");
    chk("R3 wrap value", {acc_hi, acc_lo}, 64'h8000000000000000);
    load(0, 0);
    mac(32'hABCD8000, 32'h12340002, 1'b1, 1'b0, "R4 word upper ignored");
    chk("R4 value", {acc_hi, acc_lo}, 64'hFFFFFFFFFFFF0000);

    load(32'h12345678, 0);
    mac(1, 1, 1'b0, 1'b1, "R5 pos");
    chk("R5 pos value", {acc_hi, acc_lo}, 64'h0000567800000001);
    load(32'h80000000, 0);
    mac(1, 1, 1'b0, 1'b1, "R5 neg");
    chk("R5 neg value", {acc_hi, acc_lo}, 64'hFFFF000000000001);

    load(32'hFFFFFFFF, 32'h80000000);
    mac(1, 32'h0000FFFF, 1'b1, 1'b1, "R6 below");
    chk("R6 value", {acc_hi, acc_lo}, 64'h0000000180000000);
    load(32'hFFFFFFFF, 32'h80000001);
    mac(1, 32'h0000FFFF, 1'b1, 1'b1, "R6 at min");
    chk("R6 at min value", {acc_hi, acc_lo}, 64'hFFFFFFFF80000000);
    load(0, 32'h7FFFFFFF);
    mac(1, 1, 1'b1, 1'b1, "R7 above");
    chk("R7 value", {acc_hi, acc_lo}, 64'h000000017FFFFFFF);
    load(0, 32'h7FFFFFFE);
    mac(1, 1, 1'b1, 1'b1, "R7 at max");
    chk("R7 at max value", {acc_hi, acc_lo}, 64'h000000007FFFFFFF);
    load(0, 32'h7FFFFFFF);
    mac(1, 1, 1'b1, 1'b0, "R7 sat off");
    chk("R7 sat off value", {acc_hi, acc_lo}, 64'h0000000080000000);

    // R8: clear beats load, each word independent
    @(negedge clk);
    hi_clr = 1'b1; hi_ld = 1'b1; hi_data = 32'hDEADBEEF;
    lo_ld = 1'b1; lo_data = 32'h13579BDF;
    @(negedge clk);
    hi_clr = 1'b0; hi_ld = 1'b0; lo_ld = 1'b0;
    chk("R8 clr over ld", {acc_hi, acc_lo}, {32'd0, 32'h13579BDF});
    m_hi = 0; m_lo = 32'h13579BDF;

    // R8: load hi / clear lo on the write-back edge
    @(negedge clk);
    a = 32'd100; b = 32'd3; op_word = 1'b0; sat = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    hi_ld = 1'b1; hi_data = 32'hCAFEF00D; lo_clr = 1'b1;
    @(negedge clk);
    hi_ld = 1'b0; lo_clr = 1'b0;
    chk("R8 direct over wb", {acc_hi, acc_lo}, {32'hCAFEF00D, 32'd0});
    chk("R8 done still", {63'd0, done}, 64'd1);
    m_hi = 32'hCAFEF00D; m_lo = 0;

    // R9: back-to-back requests
    load(0, 32'd10);
    @(negedge clk);
    a = 32'd5; b = 32'd6; op_word = 1'b0; sat = 1'b0; start = 1'b1;
    @(negedge clk);
    a = 32'h0001FFFE; b = 32'h00020004; op_word = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R9 first", {acc_hi, acc_lo}, 64'd40);
    @(negedge clk);
    chk("R9 second", {acc_hi, acc_lo}, 64'd32);
    chk("R9 done", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R2 single pulse", {63'd0, done}, 64'd0);
    m_hi = 0; m_lo = 32'd32;

    for (int i = 0; i < 200; i++) begin
      logic [31:0] x, y, h, l;
      bit w, s;
      x = $urandom; y = $urandom; w = $urandom_range(0, 1); s = $urandom_range(0, 1);
      if (i % 4 == 0) begin
        case ($urandom_range(0, 3))
          0: h = 32'd0;
          1: h = 32'hFFFFFFFF;
          2: h = 32'h00000001;
          default: h = $urandom;
        endcase
        l = $urandom;
        load(h, l);
      end
      if (w) mac(x, y, 1'b1, s, s ? "R7 rand word sat" : "R4 rand word");
      else   mac(x, y, 1'b0, s, s ? "R5 rand long sat" : "R3 rand long");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule